// File: doc/BRIEF.md
# Three-Phase Dead-Time Inserter with Output Protection

This block sits between three pulse-width request sources and the six gate-drive pins of a three-phase bridge. Each phase has a positive-side and a negative-side request. In normal use the negative request is the inverse of the positive one, but each side can be set on its own. For every phase the block delays the turn-on of a side by a programmable number of dead-time ticks, so that the two switches of a half-bridge never conduct during a transition. A side that is being switched off follows its request at once. One reload value serves all three per-phase counters. The tick can run at the clock rate or at a divided rate, and a bypass setting removes the delay entirely.

Protection sits around the delay logic. An interlock can stop both sides of a phase from being driven together. A sticky flag records every cycle in which both sides of any phase would be active, whether or not the interlock suppresses them. Each pin has its own active level, and a separate active level is set for the positive group and for the negative group. An active-low emergency input, gated by an enable, removes the output enables of all six pins with no clock involved. A synchronized copy of that input sets a second sticky flag. Both flags are cleared by write-one-to-clear strobes.

Top module: `deadtime_guard`

## Requirements
- R1: After reset every pin sits at its inactive level, both flags read 0 and all six output enables read 1.
- R2: With tick_sel = 0 (a tick on every clock) and bypass off, the side that is turning on stays inactive for exactly p clock cycles, counted from the first clock edge that samples the new request. Here p is dt_reload, in the range 1 to 255.
- R3: A side whose request falls goes inactive on the first clock edge that samples the fall.
- R4: Any change of either request of a phase while its count is running reloads that phase's count with p, and both sides of the phase stay inactive until the reloaded count expires.
- R5: With dt_bypass = 1, each side follows its request one clock edge later and no dead time is inserted.
- R6: tick_sel selects the dead-time tick: 0 is every clock, 1 is every 2nd clock, 2 is every 4th clock, and 3 is every 4th clock built as a halved clock halved again. For a divide ratio d, the inactive span lasts between (p-1)*d+1 and p*d clocks.
- R7: A pin's level is its logical activity XOR its polarity bit (pos_act_low for out_pos, neg_act_low for out_neg). A side is active low when its bit is 1.
- R8: With interlock_en = 1, the two sides of a phase are never active together. A phase whose two sides would both be active drives both sides inactive.
- R9: conc_flag sets on the edge after any phase has both sides logically active, whatever interlock_en is. It then holds until cleared, and a new occurrence in the same cycle as a clear strobe wins over the clear.
- R10: A pulse on clr_conc with no concurrent occurrence clears conc_flag on the next edge.
- R11: While cutoff_en = 1 and cutoff_n = 0, all six output enables are 0 in the same cycle, independent of the clock. With cutoff_en = 0, cutoff_n has no effect.
- R12: With cutoff_en = 1, a low level on cutoff_n sets cut_flag through a two-flop synchronizer, by the third clock edge. cut_flag holds until a clr_cut pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_req | input | 3 | Positive-side request, one bit per phase |
| neg_req | input | 3 | Negative-side request, one bit per phase |
| dt_reload | input | 8 | Shared dead-time reload value p |
| dt_bypass | input | 1 | 1 removes dead time |
| tick_sel | input | 2 | Dead-time tick divider select |
| pos_act_low | input | 1 | Positive pins active low when 1 |
| neg_act_low | input | 1 | Negative pins active low when 1 |
| interlock_en | input | 1 | Block concurrent activity of a phase pair |
| cutoff_n | input | 1 | Emergency cutoff, active low |
| cutoff_en | input | 1 | Enables the emergency cutoff |
| clr_conc | input | 1 | Write-one-to-clear strobe for conc_flag |
| clr_cut | input | 1 | Write-one-to-clear strobe for cut_flag |
| out_pos | output | 3 | Positive-side pin levels |
| out_neg | output | 3 | Negative-side pin levels |
| oe_pos | output | 3 | Output enables of the positive pins |
| oe_neg | output | 3 | Output enables of the negative pins |
| conc_flag | output | 1 | Sticky concurrent-activity detect |
| cut_flag | output | 1 | Sticky synchronized cutoff detect |

## Verification
A concurrent occurrence and a clear strobe can arrive in the same cycle. The clear must not swallow the event. The bench holds both requests of one phase high with the interlock off, so the occurrence repeats every cycle, and pulses clr_conc for one cycle in the middle. It then expects conc_flag to stay 1. It also clears with the pair separated and expects a 0. Random runs toss clear strobes in at random against a bench model whose flag gives priority to setting.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;

  typedef enum logic [1:0] {
    TICK_EVERY  = 2'd0,
    TICK_HALF   = 2'd1,
    TICK_QUART  = 2'd2,
    TICK_CASC   = 2'd3
  } tick_sel_e;

  // pin level from logical activity and polarity select
  function automatic logic pin_level(input logic active, input logic act_low);
    return active ^ act_low;
  endfunction

  // next value of a dead-time down counter
  function automatic logic [15:0] count_step(input logic [15:0] cur, input logic tick);
    return (tick && cur != 16'd0) ? cur - 16'd1 : cur;
  endfunction

endpackage

// File: rtl/dtg_tick.sv
`timescale 1ns/1ps
module dtg_tick #(
  parameter int PRE_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       tick
);
  import dtg_pkg::*;

  logic [PRE_W-1:0] pre;
  logic             half_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre    <= '0;
      half_t <= 1'b0;
    end else begin
      pre <= pre + 1'b1;
      if (pre[0]) half_t <= ~half_t;
    end
  end

  always_comb begin
    unique case (tick_sel_e'(sel))
      TICK_EVERY: tick = 1'b1;
      TICK_HALF:  tick = pre[0];
      TICK_QUART: tick = &pre[1:0];
      default:    tick = pre[0] & half_t;
    endcase
  end
endmodule

// File: rtl/dtg_phase.sv
`timescale 1ns/1ps
module dtg_phase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pos_req,
  input  logic             neg_req,
  input  logic [CNT_W-1:0] reload,
  input  logic             bypass,
  input  logic             tick,
  input  logic             interlock,
  output logic             pos_drv,
  output logic             neg_drv,
  output logic             both_raw,
  output logic             req_change
);
  import dtg_pkg::*;

  logic             pq, nq;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      cnt_wide;
  logic             settled, pos_l, neg_l, block;

  assign req_change = (pos_req != pq) || (neg_req != nq);
  assign cnt_wide   = 16'(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq  <= 1'b0;
      nq  <= 1'b0;
      cnt <= '0;
    end else begin
      pq <= pos_req;
      nq <= neg_req;
      if (bypass)          cnt <= '0;
      else if (req_change) cnt <= reload;
      else                 cnt <= CNT_W'(count_step(cnt_wide, tick));
    end
  end

  assign settled  = bypass || (cnt == '0);
  assign pos_l    = pq & settled;
  assign neg_l    = nq & settled;
  assign both_raw = pos_l & neg_l;
  assign block    = interlock & both_raw;
  assign pos_drv  = pos_l & ~block;
  assign neg_drv  = neg_l & ~block;
endmodule

// File: rtl/dtg_cutoff.sv
`timescale 1ns/1ps
module dtg_cutoff #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cutoff_n,
  input  logic cutoff_en,
  input  logic clr,
  output logic oe,
  output logic cut_flag
);
  logic [SYNC_N-1:0] sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync     <= '1;
      cut_flag <= 1'b0;
    end else begin
      sync     <= {sync[SYNC_N-2:0], cutoff_n};
      cut_flag <= (cut_flag & ~clr) | (cutoff_en & ~sync[SYNC_N-1]);
    end
  end

  // no clock in the release path of the pins
  assign oe = ~(cutoff_en & ~cutoff_n);
endmodule

// File: rtl/deadtime_guard.sv
`timescale 1ns/1ps
module deadtime_guard #(
  parameter int PHASES = 3,
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] pos_req,
  input  logic [PHASES-1:0] neg_req,
  input  logic [CNT_W-1:0]  dt_reload,
  input  logic              dt_bypass,
  input  logic [1:0]        tick_sel,
  input  logic              pos_act_low,
  input  logic              neg_act_low,
  input  logic              interlock_en,
  input  logic              cutoff_n,
  input  logic              cutoff_en,
  input  logic              clr_conc,
  input  logic              clr_cut,
  output logic [PHASES-1:0] out_pos,
  output logic [PHASES-1:0] out_neg,
  output logic [PHASES-1:0] oe_pos,
  output logic [PHASES-1:0] oe_neg,
  output logic              conc_flag,
  output logic              cut_flag
);
  import dtg_pkg::*;

  logic              tick;
  logic              oe_all;
  logic [PHASES-1:0] pos_drv, neg_drv, both_raw, req_change;

  dtg_tick #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .sel(tick_sel), .tick(tick)
  );

  for (genvar g = 0; g < PHASES; g++) begin : g_ph
    dtg_phase #(.CNT_W(CNT_W)) u_ph (
      .clk(clk), .rst_n(rst_n),
      .pos_req(pos_req[g]), .neg_req(neg_req[g]),
      .reload(dt_reload), .bypass(dt_bypass), .tick(tick),
      .interlock(interlock_en),
      .pos_drv(pos_drv[g]), .neg_drv(neg_drv[g]),
      .both_raw(both_raw[g]), .req_change(req_change[g])
    );
    assign out_pos[g] = pin_level(pos_drv[g], pos_act_low);
    assign out_neg[g] = pin_level(neg_drv[g], neg_act_low);
    assign oe_pos[g]  = oe_all;
    assign oe_neg[g]  = oe_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conc_flag <= 1'b0;
    else        conc_flag <= (conc_flag & ~clr_conc) | (|both_raw);
  end

  dtg_cutoff #(.SYNC_N(2)) u_cut (
    .clk(clk), .rst_n(rst_n), .cutoff_n(cutoff_n), .cutoff_en(cutoff_en),
    .clr(clr_cut), .oe(oe_all), .cut_flag(cut_flag)
  );
endmodule

// File: rtl/dtg_checker.sv
`timescale 1ns/1ps
module dtg_checker #(
  parameter int P = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         interlock_en,
  input logic         cutoff_en,
  input logic         cutoff_n,
  input logic         clr_conc,
  input logic         clr_cut,
  input logic [P-1:0] pos_drv,
  input logic [P-1:0] neg_drv,
  input logic [P-1:0] both_raw,
  input logic [P-1:0] oe_pos,
  input logic [P-1:0] oe_neg,
  input logic         conc_flag,
  input logic         cut_flag
);
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    interlock_en |-> ((pos_drv & neg_drv) == '0));

  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|both_raw) |=> conc_flag);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (conc_flag && !clr_conc) |=> conc_flag);

  a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_conc && both_raw == '0) |=> !conc_flag);

  a_r11_cut_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (cutoff_en && !cutoff_n) |-> (oe_pos == '0 && oe_neg == '0));

  a_r11_no_cut_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (!cutoff_en || cutoff_n) |-> (&oe_pos && &oe_neg));

  a_r12_cut_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_flag && !clr_cut) |=> cut_flag);
endmodule

bind deadtime_guard dtg_checker #(.P(PHASES)) u_chk (
  .clk(clk), .rst_n(rst_n), .interlock_en(interlock_en),
  .cutoff_en(cutoff_en), .cutoff_n(cutoff_n),
  .clr_conc(clr_conc), .clr_cut(clr_cut),
  .pos_drv(pos_drv), .neg_drv(neg_drv), .both_raw(both_raw),
  .oe_pos(oe_pos), .oe_neg(oe_neg),
  .conc_flag(conc_flag), .cut_flag(cut_flag)
);

// File: tb/tb_deadtime_guard.sv
`timescale 1ns/1ps
module tb_deadtime_guard;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pos_req = '0, neg_req = '0;
  logic [7:0] dt_reload = 8'd5;
  logic dt_bypass = 1'b0;
  logic [1:0] tick_sel = 2'd0;
  logic pos_act_low = 1'b0, neg_act_low = 1'b0, interlock_en = 1'b0;
  logic cutoff_n = 1'b1, cutoff_en = 1'b0, clr_conc = 1'b0, clr_cut = 1'b0;
  logic [NP-1:0] out_pos, out_neg, oe_pos, oe_neg;
  logic conc_flag, cut_flag;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  deadtime_guard dut (
    .clk(clk), .rst_n(rst_n), .pos_req(pos_req), .neg_req(neg_req),
    .dt_reload(dt_reload), .dt_bypass(dt_bypass), .tick_sel(tick_sel),
    .pos_act_low(pos_act_low), .neg_act_low(neg_act_low),
    .interlock_en(interlock_en), .cutoff_n(cutoff_n), .cutoff_en(cutoff_en),
    .clr_conc(clr_conc), .clr_cut(clr_cut),
    .out_pos(out_pos), .out_neg(out_neg), .oe_pos(oe_pos), .oe_neg(oe_neg),
    .conc_flag(conc_flag), .cut_flag(cut_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // inactive span of the side turning on; also reports whether the other
  // side was already off at the first sample (polarity assumed active high)
  task automatic measure(input int ph, input bit want_pos, output int n, output bit old_off);
    n = 0;
    old_off = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (k == 0) old_off = want_pos ? !out_neg[ph] : !out_pos[ph];
      if (want_pos ? out_pos[ph] : out_neg[ph]) break;
      n++;
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // bench model for the random phase
  bit m_pq[NP], m_nq[NP];
  int m_cnt[NP];
  bit m_flag;

  function automatic bit m_pos(int i);
    bit pl = m_pq[i] && m_cnt[i] == 0;
    bit nl = m_nq[i] && m_cnt[i] == 0;
    return pl && !(interlock_en && pl && nl);
  endfunction
  function automatic bit m_neg(int i);
    bit pl = m_pq[i] && m_cnt[i] == 0;
    bit nl = m_nq[i] && m_cnt[i] == 0;
    return nl && !(interlock_en && pl && nl);
  endfunction
  function automatic bit m_both_any();
    bit b = 1'b0;
    for (int i = 0; i < NP; i++) b |= m_pq[i] && m_nq[i] && m_cnt[i] == 0;
    return b;
  endfunction

  initial begin
    int n;
    bit off;
    void'($urandom(32'h1d3a_77c5));
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_pos", out_pos, 0);
    chk("R1 out_neg", out_neg, 0);
    chk("R1 oe", {oe_pos, oe_neg}, 6'h3f);
    chk("R1 flags", {conc_flag, cut_flag}, 0);

    // R2, R3: negative side active, then flip phase 0
    dt_reload = 8'd5;
    neg_req = '1;
    cyc(12);
    pos_req[0] = 1'b1; neg_req[0] = 1'b0;
    measure(0, 1'b1, n, off);
    chk("R2 dead span p=5", n, 5);
    chk("R3 old side off at first edge", off, 1);
    dt_reload = 8'd1;
    pos_req[1] = 1'b1; neg_req[1] = 1'b0;
    measure(1, 1'b1, n, off);
    chk("R2 dead span p=1", n, 1);

    // R6 divided ticks
    dt_reload = 8'd7; tick_sel = 2'd1;
    pos_req[0] = 1'b0; neg_req[0] = 1'b1;
    measure(0, 1'b0, n, off);
    chk_rng("R6 div2 span", n, 13, 14);
    chk("R3 pos off", off, 1);
    dt_reload = 8'd3; tick_sel = 2'd2;
    pos_req[0] = 1'b1; neg_req[0] = 1'b0;
    measure(0, 1'b1, n, off);
    chk_rng("R6 div4 span", n, 9, 12);
    tick_sel = 2'd3;
    pos_req[0] = 1'b0; neg_req[0] = 1'b1;
    measure(0, 1'b0, n, off);
    chk_rng("R6 cascaded div4 span", n, 9, 12);
    tick_sel = 2'd0;

    // R4 re-toggle during the count restarts it
    dt_reload = 8'd10;
    cyc(2);
    pos_req[2] = 1'b1; neg_req[2] = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        seen += out_pos[2] + out_neg[2];
      end
      chk("R4 both inactive while counting", seen, 0);
    end
    pos_req[2] = 1'b0; neg_req[2] = 1'b1;
    measure(2, 1'b0, n, off);
    chk("R4 restarted span", n, 10);

    // R5 bypass
    dt_bypass = 1'b1;
    pos_req[2] = 1'b1; neg_req[2] = 1'b0;
    @(negedge clk);
    chk("R5 bypass new side on", out_pos[2], 1);
    chk("R5 bypass old side off", out_neg[2], 0);
    dt_bypass = 1'b0;
    cyc(2);

    // R7 polarity: phase 2 pos active, neg inactive
    pos_act_low = 1'b1; neg_act_low = 1'b1;
    #1;
    chk("R7 active-low pos pin", out_pos[2], 0);
    chk("R7 active-low neg pin", out_neg[2], 1);
    pos_act_low = 1'b0; neg_act_low = 1'b0;

    // R8, R9, R10 concurrent requests
    dt_reload = 8'd2;
    clr_conc = 1'b1; @(negedge clk); clr_conc = 1'b0;
    chk("R10 clear idle flag", conc_flag, 0);
    interlock_en = 1'b1;
    pos_req[0] = 1'b1; neg_req[0] = 1'b1;
    cyc(5);
    chk("R8 interlock blocks pair", {out_pos[0], out_neg[0]}, 0);
    chk("R9 detect with interlock", conc_flag, 1);
    neg_req[0] = 1'b0;
    cyc(2);
    chk("R9 flag sticky", conc_flag, 1);
    clr_conc = 1'b1; @(negedge clk); clr_conc = 1'b0;
    chk("R10 clear", conc_flag, 0);
    interlock_en = 1'b0;
    neg_req[0] = 1'b1;
    cyc(5);
    chk("R8 no interlock both active", {out_pos[0], out_neg[0]}, 3);
    clr_conc = 1'b1; @(negedge clk); clr_conc = 1'b0;
    chk("R9 set wins over clear", conc_flag, 1);
    neg_req[0] = 1'b0;
    cyc(3);

    // R11, R12 cutoff
    cutoff_n = 1'b0;
    #1;
    chk("R11 disabled cutoff oe", {oe_pos, oe_neg}, 6'h3f);
    cyc(5);
    chk("R12 disabled cutoff flag", cut_flag, 0);
    cutoff_en = 1'b1;
    #1;
    chk("R11 immediate oe drop", {oe_pos, oe_neg}, 0);
    cyc(4);
    chk("R12 cut flag set", cut_flag, 1);
    cutoff_n = 1'b1;
    #1;
    chk("R11 oe back", {oe_pos, oe_neg}, 6'h3f);
    cyc(4);
    chk("R12 cut flag sticky", cut_flag, 1);
    clr_cut = 1'b1; @(negedge clk); clr_cut = 1'b0;
    chk("R12 cut flag clear", cut_flag, 0);
    cutoff_en = 1'b0;

    // random phase against the bench model, tick every clock
    for (int batch = 0; batch < 2; batch++) begin
      interlock_en = batch[0];
      dt_reload = 8'($urandom_range(1, 4));
      cyc(30);
      clr_conc = 1'b1; @(negedge clk); clr_conc = 1'b0;
      for (int i = 0; i < NP; i++) begin
        m_pq[i] = pos_req[i]; m_nq[i] = neg_req[i]; m_cnt[i] = 0;
      end
      m_flag = 1'b0;
      for (int it = 0; it < 400; it++) begin
        bit bad = 1'b0;
        bit b;
        for (int i = 0; i < NP; i++) begin
          if (out_pos[i] !== m_pos(i) || out_neg[i] !== m_neg(i)) bad = 1'b1;
        end
        if (conc_flag !== m_flag) bad = 1'b1;
        checks++;
        if (bad) begin
          fails++;
          $display("FAIL R2/R8/R9 random it=%0d actual=%0d expected=%0d", it,
                   {out_pos, out_neg, conc_flag},
                   {m_pos(2), m_pos(1), m_pos(0), m_neg(2), m_neg(1), m_neg(0), m_flag});
        end
        for (int i = 0; i < NP; i++) begin
          if ($urandom_range(0, 3) == 0) begin
            pos_req[i] = ~pos_req[i];
            neg_req[i] = ($urandom_range(0, 7) == 0) ? pos_req[i] : ~pos_req[i];
          end
        end
        clr_conc = ($urandom_range(0, 15) == 0);
        b = m_both_any();
        m_flag = (m_flag && !clr_conc) || b;
        for (int i = 0; i < NP; i++) begin
          if (pos_req[i] != m_pq[i] || neg_req[i] != m_nq[i]) m_cnt[i] = int'(dt_reload);
          else if (m_cnt[i] != 0) m_cnt[i]--;
          m_pq[i] = pos_req[i]; m_nq[i] = neg_req[i];
        end
        @(negedge clk);
      end
      clr_conc = 1'b0;
    end

    finish_run();
  end
endmodule